// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block tracks the fetch status of every hardware thread in a multithreaded instruction fetch stage. Each cycle it collects sticky stall requests from four downstream stages (decode, rename, execute, commit), a global context-switch stall, squash requests from commit and from decode, a "reorder buffer still squashing" indication, and events from the fetch engine: a line request sent or refused, a retry accepted, a trap or quiesce seen, and a fetch turn. It also receives instruction-cache completions tagged with a thread number and a request tag.

The controller keeps one registered state per thread, a redirect target on every squash it takes, and a per-thread request tag that the fetch engine attaches to its next cache request. A completion is accepted only when its thread is still waiting and its tag matches the outstanding request. Any other completion is dropped and counted. A registered stage-active flag tells the pipeline whether any thread has useful fetch work to do. Branch prediction, translation and the cache itself live elsewhere.

Top module: `fetch_thread_ctrl`

## Requirements
- R1: After reset every thread is in Running (code 0), with all stall bits clear. The issue tag of each thread is 0, the drop count is 0, no redirect is flagged, and stage_active is 0.
- R2: State codes are Running 0, Idle 1, Squashing 2, Blocked 3, WaitResponse 4, WaitRetry 5, AccessComplete 6, TrapPending 7 and QuiescePending 8. A thread whose thread_active bit is 0 goes to Idle and ignores all other inputs. An Idle thread that is active again returns to Running.
- R3: Each of the four stages has a sticky stall bit per thread. A block pulse sets the bit and an unblock pulse clears it. A thread with any bit set enters Blocked. It stays Blocked until all four bits are clear, and then returns to Running. Block and unblock for the same stage and thread in one cycle are illegal.
- R4: While ctx_stall is 1, every active thread that is not in WaitResponse enters or stays in Blocked.
- R5: A commit squash has the highest priority among the non-idle inputs. The thread enters Squashing. redirect_pc takes the commit target, redirect_next_pc equals that target plus INST_BYTES, and redirect_valid pulses for one cycle. Any outstanding request is cancelled. A decode squash in the same cycle is overridden.
- R6: While rob_squashing is 1 (and there is no commit squash), the thread stays in Squashing.
- R7: A decode squash is taken only when the thread is not already in Squashing. When taken, it behaves like R5 with the decode target. When ignored, redirect_valid stays 0 and redirect_pc keeps its value.
- R8: Stall bits and ctx_stall do not move a thread out of WaitResponse.
- R9: A thread in Squashing or Blocked that sees no squash, no ROB squashing and no stall this cycle returns to Running.
- R10: From Running, a thread follows this priority. req_sent moves it to WaitResponse. req_refused moves it to WaitRetry. trap_hit moves it to TrapPending, and quiesce_hit moves it to QuiescePending. req_sent and req_refused record the current issue tag as outstanding, and the issue tag then advances by 1 modulo 2^TAG_W. retry_ok moves WaitRetry to WaitResponse. TrapPending and QuiescePending hold until a squash or stall.
- R11: An accepted completion moves the thread to Blocked if a stall is present, otherwise to AccessComplete. AccessComplete holds until fetch_turn, which moves the thread to Running.
- R12: A completion is accepted only if its thread is in WaitResponse and its tag equals the outstanding tag. Any other completion leaves the thread's state unchanged and increments drop_count by 1.
- R13: stage_active is 1 exactly when some active thread is in Running, Squashing or AccessComplete. The flag is registered, so it is aligned with the registered thread states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_active | input | NT | Thread enabled for fetch |
| dec_block | input | NT | Decode stall set pulse |
| dec_unblock | input | NT | Decode stall clear pulse |
| ren_block | input | NT | Rename stall set pulse |
| ren_unblock | input | NT | Rename stall clear pulse |
| exe_block | input | NT | Execute stall set pulse |
| exe_unblock | input | NT | Execute stall clear pulse |
| cmt_block | input | NT | Commit stall set pulse |
| cmt_unblock | input | NT | Commit stall clear pulse |
| ctx_stall | input | 1 | Context-switch stall for all threads |
| cmt_squash | input | NT | Squash request from commit |
| cmt_squash_pc | input | NT*PC_W | Commit redirect target per thread |
| rob_squashing | input | NT | Reorder buffer still squashing |
| dec_squash | input | NT | Squash request from decode |
| dec_squash_pc | input | NT*PC_W | Decode redirect target per thread |
| req_sent | input | NT | Line request accepted by cache |
| req_refused | input | NT | Line request refused by cache |
| retry_ok | input | NT | Refused request accepted on retry |
| trap_hit | input | NT | Fetch raised a trap |
| quiesce_hit | input | NT | Fetch met a quiesce instruction |
| fetch_turn | input | NT | Thread got its fetch turn |
| cmpl_valid | input | 1 | Cache completion this cycle |
| cmpl_tid | input | TID_W | Completion thread number |
| cmpl_tag | input | TAG_W | Completion request tag |
| thread_state | output | NT*4 | Registered state code per thread |
| redirect_valid | output | NT | One-cycle pulse after a taken squash |
| redirect_pc | output | NT*PC_W | Last redirect target |
| redirect_next_pc | output | NT*PC_W | Redirect target plus INST_BYTES |
| issue_tag | output | NT*TAG_W | Tag to attach to the next request |
| stage_active | output | 1 | Some active thread can fetch |
| drop_count | output | DROP_W | Count of discarded completions |

## Verification
The bench builds the block with two threads, a 2-bit tag, a 16-bit PC and a 4-byte instruction size. With this configuration it can sweep every stage's stall source on both threads. The tag wraps within a few requests, so the bench can walk every tag value through a completion, both as the matching tag and as a stale one. Two threads are enough to show that a completion carrying the wrong thread number is dropped even when its tag matches, and to exercise stage_active with one thread idle or blocked while the other keeps fetching.

// File: rtl/fetch_ctrl_pkg.sv
package fetch_ctrl_pkg;

    typedef enum logic [3:0] {
        ST_RUN     = 4'd0,
        ST_IDLE    = 4'd1,
        ST_SQUASH  = 4'd2,
        ST_BLOCK   = 4'd3,
        ST_WRESP   = 4'd4,
        ST_WRETRY  = 4'd5,
        ST_ACCDONE = 4'd6,
        ST_TRAP    = 4'd7,
        ST_QUIESCE = 4'd8
    } fstate_e;

    localparam int NUM_STAGES = 4;

    function automatic logic can_fetch(fstate_e s);
        return (s == ST_RUN) || (s == ST_SQUASH) || (s == ST_ACCDONE);
    endfunction

endpackage

// File: rtl/fetch_stall_tracker.sv
module fetch_stall_tracker #(
    parameter int NT = 2,
    localparam int NS = fetch_ctrl_pkg::NUM_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NS*NT-1:0] block,
    input  logic [NS*NT-1:0] unblock,
    output logic [NT-1:0]    stall_now
);

    typedef struct packed {
        logic [NS*NT-1:0] bits;
    } trk_t;

    trk_t q, d;

    always_comb begin
        d      = q;
        d.bits = (q.bits | block) & ~unblock;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic [NS-1:0] col;
        for (genvar s = 0; s < NS; s++) begin : g_stg
            assign col[s] = d.bits[s*NT + t];
        end
        assign stall_now[t] = |col;
    end

    AST_NO_BLK_UNB: assert property (@(posedge clk) disable iff (!rst_n)
        (block & unblock) == '0); // R3

endmodule

// File: rtl/fetch_thread_fsm.sv
module fetch_thread_fsm
    import fetch_ctrl_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int TAG_W      = 3,
    parameter int INST_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             stall,
    input  logic             cmt_sq,
    input  logic [PC_W-1:0]  cmt_pc,
    input  logic             rob_sq,
    input  logic             dec_sq,
    input  logic [PC_W-1:0]  dec_pc,
    input  logic             req_sent,
    input  logic             req_refused,
    input  logic             retry_ok,
    input  logic             trap_hit,
    input  logic             quiesce_hit,
    input  logic             fetch_turn,
    input  logic             cmpl_hit,
    input  logic [TAG_W-1:0] cmpl_tag,
    output logic [3:0]       state,
    output logic [3:0]       state_nxt,
    output logic             redir_vld,
    output logic [PC_W-1:0]  redir_pc,
    output logic [PC_W-1:0]  redir_next_pc,
    output logic [TAG_W-1:0] issue_tag,
    output logic             cmpl_accept
);

    typedef struct packed {
        fstate_e          st;
        logic             vld;
        logic [PC_W-1:0]  pc;
        logic [TAG_W-1:0] tag;
        logic [TAG_W-1:0] otag;
    } thr_t;

    thr_t q, d;

    assign cmpl_accept = cmpl_hit && (q.st == ST_WRESP) && (cmpl_tag == q.otag);

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (!active) begin
            d.st = ST_IDLE;
        end else if (q.st == ST_IDLE) begin
            d.st = ST_RUN;
        end else if (cmt_sq) begin
            d.st  = ST_SQUASH;
            d.pc  = cmt_pc;
            d.vld = 1'b1;
        end else if (rob_sq) begin
            d.st = ST_SQUASH;
        end else if (dec_sq && q.st != ST_SQUASH) begin
            d.st  = ST_SQUASH;
            d.pc  = dec_pc;
            d.vld = 1'b1;
        end else if (stall && q.st != ST_WRESP) begin
            d.st = ST_BLOCK;
        end else begin
            unique case (q.st)
                ST_BLOCK, ST_SQUASH: d.st = ST_RUN;
                ST_RUN: begin
                    if (req_sent || req_refused) begin
                        d.st   = req_sent ? ST_WRESP : ST_WRETRY;
                        d.otag = q.tag;
                        d.tag  = q.tag + TAG_W'(1);
                    end else if (trap_hit) begin
                        d.st = ST_TRAP;
                    end else if (quiesce_hit) begin
                        d.st = ST_QUIESCE;
                    end
                end
                ST_WRETRY:  if (retry_ok) d.st = ST_WRESP;
                ST_WRESP:   if (cmpl_accept) d.st = stall ? ST_BLOCK : ST_ACCDONE;
                ST_ACCDONE: if (fetch_turn) d.st = ST_RUN;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_RUN;
        end else begin
            q <= d;
        end
    end

    assign state         = q.st;
    assign state_nxt     = d.st;
    assign redir_vld     = q.vld;
    assign redir_pc      = q.pc;
    assign redir_next_pc = q.pc + PC_W'(INST_BYTES);
    assign issue_tag     = q.tag;

    AST_CMT_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
        (active && q.st != ST_IDLE && cmt_sq) |=>
        (state == 4'd2 && redir_vld && redir_pc == $past(cmt_pc))); // R5

    AST_ROB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && q.st != ST_IDLE && rob_sq) |=> (state == 4'd2)); // R6

    AST_DEC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (active && q.st == ST_SQUASH && dec_sq && !cmt_sq && !rob_sq) |=>
        (!redir_vld && $stable(redir_pc))); // R7

    AST_WRESP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (active && q.st == ST_WRESP && !cmt_sq && !rob_sq && !dec_sq && !cmpl_accept) |=>
        (state == 4'd4)); // R8

endmodule

// File: rtl/fetch_thread_ctrl.sv
module fetch_thread_ctrl
    import fetch_ctrl_pkg::*;
#(
    parameter int NT         = 2,
    parameter int PC_W       = 32,
    parameter int TAG_W      = 3,
    parameter int INST_BYTES = 4,
    parameter int DROP_W     = 8,
    parameter int TID_W      = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NT-1:0]     thread_active,
    input  logic [NT-1:0]     dec_block,
    input  logic [NT-1:0]     dec_unblock,
    input  logic [NT-1:0]     ren_block,
    input  logic [NT-1:0]     ren_unblock,
    input  logic [NT-1:0]     exe_block,
    input  logic [NT-1:0]     exe_unblock,
    input  logic [NT-1:0]     cmt_block,
    input  logic [NT-1:0]     cmt_unblock,
    input  logic              ctx_stall,
    input  logic [NT-1:0]     cmt_squash,
    input  logic [NT*PC_W-1:0] cmt_squash_pc,
    input  logic [NT-1:0]     rob_squashing,
    input  logic [NT-1:0]     dec_squash,
    input  logic [NT*PC_W-1:0] dec_squash_pc,
    input  logic [NT-1:0]     req_sent,
    input  logic [NT-1:0]     req_refused,
    input  logic [NT-1:0]     retry_ok,
    input  logic [NT-1:0]     trap_hit,
    input  logic [NT-1:0]     quiesce_hit,
    input  logic [NT-1:0]     fetch_turn,
    input  logic              cmpl_valid,
    input  logic [TID_W-1:0]  cmpl_tid,
    input  logic [TAG_W-1:0]  cmpl_tag,
    output logic [NT*4-1:0]   thread_state,
    output logic [NT-1:0]     redirect_valid,
    output logic [NT*PC_W-1:0] redirect_pc,
    output logic [NT*PC_W-1:0] redirect_next_pc,
    output logic [NT*TAG_W-1:0] issue_tag,
    output logic              stage_active,
    output logic [DROP_W-1:0] drop_count
);

    localparam int NS = NUM_STAGES;

    logic [NT-1:0] stall_bits;
    logic [NT-1:0] accept;
    logic [NT-1:0] fetchable_nxt;
    logic [3:0]    st_nxt [NT];

    fetch_stall_tracker #(.NT(NT)) u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .block     ({cmt_block, exe_block, ren_block, dec_block}),
        .unblock   ({cmt_unblock, exe_unblock, ren_unblock, dec_unblock}),
        .stall_now (stall_bits)
    );

    for (genvar i = 0; i < NT; i++) begin : g_thr
        fetch_thread_fsm #(.PC_W(PC_W), .TAG_W(TAG_W), .INST_BYTES(INST_BYTES)) u_fsm (
            .clk           (clk),
            .rst_n         (rst_n),
            .active        (thread_active[i]),
            .stall         (stall_bits[i] | ctx_stall),
            .cmt_sq        (cmt_squash[i]),
            .cmt_pc        (cmt_squash_pc[i*PC_W +: PC_W]),
            .rob_sq        (rob_squashing[i]),
            .dec_sq        (dec_squash[i]),
            .dec_pc        (dec_squash_pc[i*PC_W +: PC_W]),
            .req_sent      (req_sent[i]),
            .req_refused   (req_refused[i]),
            .retry_ok      (retry_ok[i]),
            .trap_hit      (trap_hit[i]),
            .quiesce_hit   (quiesce_hit[i]),
            .fetch_turn    (fetch_turn[i]),
            .cmpl_hit      (cmpl_valid && (cmpl_tid == TID_W'(i))),
            .cmpl_tag      (cmpl_tag),
            .state         (thread_state[i*4 +: 4]),
            .state_nxt     (st_nxt[i]),
            .redir_vld     (redirect_valid[i]),
            .redir_pc      (redirect_pc[i*PC_W +: PC_W]),
            .redir_next_pc (redirect_next_pc[i*PC_W +: PC_W]),
            .issue_tag     (issue_tag[i*TAG_W +: TAG_W]),
            .cmpl_accept   (accept[i])
        );
        assign fetchable_nxt[i] = thread_active[i] && can_fetch(fstate_e'(st_nxt[i]));
    end

    typedef struct packed {
        logic              act;
        logic [DROP_W-1:0] cnt;
    } top_t;

    top_t q, d;

    always_comb begin
        d     = q;
        d.act = |fetchable_nxt;
        if (cmpl_valid && accept == '0) d.cnt = q.cnt + DROP_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stage_active = q.act;
    assign drop_count   = q.cnt;

    AST_ACCEPT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(accept)); // R12

    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && accept == '0) |=> (drop_count == $past(drop_count) + DROP_W'(1))); // R12

    AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmpl_valid || accept != '0) |=> $stable(drop_count)); // R12

endmodule

// File: tb/fetch_thread_ctrl_tb_top.sv
module fetch_thread_ctrl_tb_top;

    localparam int NT = 2, PC_W = 16, TAG_W = 2, IB = 4, DW = 8, TW = 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NT-1:0] thread_active, dec_block, dec_unblock, ren_block, ren_unblock;
    logic [NT-1:0] exe_block, exe_unblock, cmt_block, cmt_unblock;
    logic ctx_stall;
    logic [NT-1:0] cmt_squash, rob_squashing, dec_squash;
    logic [NT*PC_W-1:0] cmt_squash_pc, dec_squash_pc;
    logic [NT-1:0] req_sent, req_refused, retry_ok, trap_hit, quiesce_hit, fetch_turn;
    logic cmpl_valid;
    logic [TW-1:0] cmpl_tid;
    logic [TAG_W-1:0] cmpl_tag;
    logic [NT*4-1:0] thread_state;
    logic [NT-1:0] redirect_valid;
    logic [NT*PC_W-1:0] redirect_pc, redirect_next_pc;
    logic [NT*TAG_W-1:0] issue_tag;
    logic stage_active;
    logic [DW-1:0] drop_count;

    int checks = 0, fails = 0, exp_drop = 0;
    bit done = 0;

    fetch_thread_ctrl #(.NT(NT), .PC_W(PC_W), .TAG_W(TAG_W), .INST_BYTES(IB),
                        .DROP_W(DW), .TID_W(TW)) dut_i (.*);

    always #2 clk = ~clk;

    task automatic chk(string r, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    function automatic int st(int t);
        return int'(thread_state[t*4 +: 4]);
    endfunction

    task automatic clr();
        {dec_block, dec_unblock, ren_block, ren_unblock} = '0;
        {exe_block, exe_unblock, cmt_block, cmt_unblock} = '0;
        {cmt_squash, rob_squashing, dec_squash} = '0;
        {req_sent, req_refused, retry_ok, trap_hit, quiesce_hit, fetch_turn} = '0;
        cmpl_valid = 1'b0;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        clr();
    endtask

    task automatic stage_pulse(int s, int t, bit blk);
        case (s)
            0: if (blk) dec_block[t] = 1'b1; else dec_unblock[t] = 1'b1;
            1: if (blk) ren_block[t] = 1'b1; else ren_unblock[t] = 1'b1;
            2: if (blk) exe_block[t] = 1'b1; else exe_unblock[t] = 1'b1;
            default: if (blk) cmt_block[t] = 1'b1; else cmt_unblock[t] = 1'b1;
        endcase
    endtask

    task automatic csq(int t, int pc);
        cmt_squash[t] = 1'b1;
        cmt_squash_pc[t*PC_W +: PC_W] = PC_W'(pc);
    endtask

    task automatic cmpl(int t, int tag);
        cmpl_valid = 1'b1;
        cmpl_tid = TW'(t);
        cmpl_tag = TAG_W'(tag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
            $finish;
        end
    end

    initial begin
        clr();
        thread_active = 2'b11; ctx_stall = 0;
        cmt_squash_pc = '0; dec_squash_pc = '0; cmpl_tid = '0; cmpl_tag = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        chk("R1 st0", st(0), 0); chk("R1 st1", st(1), 0);
        chk("R1 active", int'(stage_active), 0); chk("R1 drop", int'(drop_count), 0);
        chk("R1 redir", int'(redirect_valid), 0); chk("R1 tag", int'(issue_tag), 0);
        cyc();
        chk("R13 active running", int'(stage_active), 1);

        // R3 sweep of every stall source on every thread
        for (int t = 0; t < NT; t++)
            for (int s = 0; s < 4; s++) begin
                stage_pulse(s, t, 1); cyc();
                chk("R3 blocked", st(t), 3); chk("R3 other", st(1-t), 0);
                cyc(); chk("R3 sticky", st(t), 3);
                stage_pulse(s, t, 0); cyc(); chk("R3 released", st(t), 0);
            end
        stage_pulse(0, 0, 1); stage_pulse(3, 0, 1); cyc();
        stage_pulse(0, 0, 0); cyc(); chk("R3 one of two left", st(0), 3);
        stage_pulse(3, 0, 0); cyc(); chk("R3 all clear", st(0), 0);

        // R4 context stall
        ctx_stall = 1; cyc();
        chk("R4 st0", st(0), 3); chk("R4 st1", st(1), 3);
        chk("R13 all blocked", int'(stage_active), 0);
        ctx_stall = 0; cyc();
        chk("R9 st0", st(0), 0); chk("R13 back", int'(stage_active), 1);

        // R5 commit squash
        csq(0, 16'h1230); cyc();
        chk("R5 state", st(0), 2); chk("R5 valid", int'(redirect_valid[0]), 1);
        chk("R5 pc", int'(redirect_pc[0 +: PC_W]), 16'h1230);
        chk("R5 next", int'(redirect_next_pc[0 +: PC_W]), 16'h1230 + IB);
        cyc();
        chk("R9 squash done", st(0), 0); chk("R5 pulse", int'(redirect_valid[0]), 0);

        // R6 rob squashing
        csq(0, 16'h2000); cyc();
        rob_squashing[0] = 1; cyc(); chk("R6 hold1", st(0), 2);
        rob_squashing[0] = 1; cyc(); chk("R6 hold2", st(0), 2);
        cyc(); chk("R6 release", st(0), 0);

        // R7 decode squash
        csq(0, 16'h3000); cyc();
        dec_squash[0] = 1; dec_squash_pc[0 +: PC_W] = 16'h4000; cyc();
        chk("R7 ignored st", st(0), 0); chk("R7 ignored valid", int'(redirect_valid[0]), 0);
        chk("R7 ignored pc", int'(redirect_pc[0 +: PC_W]), 16'h3000);
        dec_squash[0] = 1; dec_squash_pc[0 +: PC_W] = 16'h4000; cyc();
        chk("R7 taken st", st(0), 2); chk("R7 taken pc", int'(redirect_pc[0 +: PC_W]), 16'h4000);
        chk("R7 next", int'(redirect_next_pc[0 +: PC_W]), 16'h4000 + IB);
        cyc();
        csq(1, 16'h5000); dec_squash[1] = 1; dec_squash_pc[PC_W +: PC_W] = 16'h6000; cyc();
        chk("R5 priority pc", int'(redirect_pc[PC_W +: PC_W]), 16'h5000);
        cyc();
        stage_pulse(0, 0, 1); csq(1, 16'h0100); cyc();
        chk("R13 squashing counts", int'(stage_active), 1);
        stage_pulse(0, 0, 0); cyc();

        // R10 R11 R12 request lifecycle on thread 0
        chk("R10 tag0", int'(issue_tag[1:0]), 0);
        req_sent[0] = 1; cyc();
        chk("R10 wresp", st(0), 4); chk("R10 tag1", int'(issue_tag[1:0]), 1);
        stage_pulse(0, 0, 1); cyc(); chk("R8 wresp holds", st(0), 4);
        cmpl(0, 1); cyc(); exp_drop++;
        chk("R12 stale tag st", st(0), 4); chk("R12 drop", int'(drop_count), exp_drop);
        cmpl(0, 0); cyc();
        chk("R11 to blocked", st(0), 3); chk("R12 no drop", int'(drop_count), exp_drop);
        stage_pulse(0, 0, 0); cyc(); chk("R9 run", st(0), 0);
        req_sent[0] = 1; cyc(); cmpl(0, 1); cyc();
        chk("R11 access done", st(0), 6);
        cyc(); chk("R11 held", st(0), 6);
        fetch_turn[0] = 1; cyc(); chk("R11 turn", st(0), 0);
        req_refused[0] = 1; cyc();
        chk("R10 wretry", st(0), 5); chk("R10 tag3", int'(issue_tag[1:0]), 3);
        retry_ok[0] = 1; cyc(); chk("R10 retry", st(0), 4);
        cmpl(0, 2); cyc(); chk("R11 retry done", st(0), 6);
        fetch_turn[0] = 1; cyc();
        req_sent[0] = 1; cyc(); chk("R10 tag wrap", int'(issue_tag[1:0]), 0);
        csq(0, 16'h0040); cyc(); chk("R5 cancel st", st(0), 2);
        cmpl(0, 3); cyc(); exp_drop++;
        chk("R12 cancelled drop", int'(drop_count), exp_drop); chk("R9 after", st(0), 0);
        req_sent[0] = 1; cyc();
        cmpl(1, 0); cyc(); exp_drop++;
        chk("R12 wrong thread", int'(drop_count), exp_drop);
        chk("R12 t0 waits", st(0), 4); chk("R12 t1 same", st(1), 0);
        cmpl(0, 0); cyc(); chk("R11 t0", st(0), 6);
        fetch_turn[0] = 1; cyc();

        // R12 tag sweep on thread 1
        for (int k = 0; k < 8; k++) begin
            int et;
            et = k % 4;
            chk("R10 sweep tag", int'(issue_tag[3:2]), et);
            req_sent[1] = 1; cyc();
            cmpl(1, (et + 1) % 4); cyc(); exp_drop++;
            chk("R12 sweep drop", int'(drop_count), exp_drop);
            cmpl(1, et); cyc(); chk("R11 sweep accept", st(1), 6);
            fetch_turn[1] = 1; cyc(); chk("R11 sweep run", st(1), 0);
        end

        // R10 trap and quiesce
        trap_hit[0] = 1; cyc(); chk("R10 trap", st(0), 7);
        cyc(); chk("R10 trap held", st(0), 7);
        csq(0, 16'h0080); cyc(); chk("R5 from trap", st(0), 2);
        cyc();
        quiesce_hit[0] = 1; cyc(); chk("R10 quiesce", st(0), 8);
        csq(0, 16'h0090); cyc(); cyc();

        // R2 inactive thread
        thread_active = 2'b01; cyc(); chk("R2 idle", st(1), 1);
        csq(1, 16'h0777); cyc();
        chk("R2 squash ignored", st(1), 1); chk("R2 no redirect", int'(redirect_valid[1]), 0);
        stage_pulse(0, 0, 1); cyc();
        chk("R13 blocked+idle", int'(stage_active), 0);
        thread_active = 2'b11; cyc(); chk("R2 wake", st(1), 0);
        chk("R13 t1 running", int'(stage_active), 1);
        stage_pulse(0, 0, 0); cyc(); chk("R9 final", st(0), 0);

        done = 1;
        summary();
        $finish;
    end

endmodule